// File: doc/BRIEF.md
# Round-Key Schedule Engine for a Scalable Feistel Cipher

This block is the key side of a one-round-per-clock Feistel cipher loop. It holds the cipher key as two equal halves in registers. On command it applies one key round per clock cycle. The cipher's data path reads one half of the current key state as its round key. The width of the whole key (`N_BITS`) and the word size (`W`) are parameters. `N_BITS` must be a multiple of `6*W`, so that each half splits into `NB = N_BITS/(2*W)` words and those words fall into groups of three.

A key round does three things to the halves:
- The old right half becomes the new left half.
- The right half is summed word by word with a round constant. The constant is non-zero only in its least significant word, which holds the round index.
- The sum passes through a 3-bit substitution that works across each group of three words. The result is rotated bit-wise, then word-wise, and XORed into the old left half to form the new right half.

At the midpoint of a schedule the sequencer asks for the halves to be exchanged. From then on it selects the left half for the data path instead of the right half. The sequencer outside this block chooses the round count, the index values and the timing of the commands.

Every clock edge performs one of four register updates, chosen in fixed priority:
- **LOAD** (`load` = 1): capture a new key.
- **ROUND_SWAP** (`advance` = 1, `swap` = 1): run a key round on the exchanged halves.
- **ROUND** (`advance` = 1, `swap` = 0): run a plain key round.
- **HOLD** (otherwise): keep the state.

Each of these update selections can follow any other on the next edge. The choice depends only on the inputs of that cycle.

Top module: `sks_key_sched`

## Requirements
- R1: While `rst_n` is low, both key halves are zero, so `rk` reads zero for either value of `half_sel`.
- R2: A cycle with `load` = 1 puts `key[N_BITS-1:N_BITS/2]` in the left half and `key[N_BITS/2-1:0]` in the right half at the next edge. This happens whatever `advance` and `swap` hold in that cycle.
- R3: A cycle with `advance` = 1, `swap` = 0 and `load` = 0 makes the new left half equal to the old right half. The new right half is the old left half XOR T(old right half, `rc_idx`), where T is the transform described in R4 to R6.
- R4: T first adds `rc_idx` to word 0 (bits `W-1:0`) modulo 2^W, with no carry into word 1. All other words pass unchanged.
- R5: T then substitutes, for each bit position j and each group g of words 3g, 3g+1 and 3g+2. The 3-bit value {word 3g+2 bit j, word 3g+1 bit j, word 3g bit j} is replaced through the table 0→0, 1→5, 2→6, 3→7, 4→4, 5→3, 6→1, 7→2.
- R6: T then rotates each word 3g right by one bit cyclically. Each word 3g+2 is rotated left by one bit, and each word 3g+1 is unchanged. Finally every word i moves to position i+1, and the top word moves to position 0.
- R7: A cycle with `advance` = 1, `swap` = 1 and `load` = 0 performs the R3 round with the two halves exchanged at its input. The new left half equals the old left half, and the new right half is the old right half XOR T(old left half, `rc_idx`).
- R8: A cycle with `load` = 0 and `advance` = 0 leaves both halves unchanged, and `swap` has no effect in it.
- R9: `rk` shows the right half when `half_sel` = 0 and the left half when `half_sel` = 1, in the same cycle, without a clock edge.
- R10: Over a full schedule of odd length nr, the sequencer issues these commands:
  - During the first floor(nr/2) rounds it uses `half_sel` = 0 and index 1, 2, … up to floor(nr/2).
  - In the round numbered ceil(nr/2) it uses `half_sel` = 0, asserts `swap`, and uses index floor(nr/2).
  - During the remaining rounds it uses `half_sel` = 1, with the index counting down to 1.

  With these commands, the round keys delivered by `rk` match the cipher's key schedule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture `key` into the halves |
| key | input | N_BITS | Cipher key; upper half goes to the left half |
| advance | input | 1 | Perform one key round |
| swap | input | 1 | Exchange halves ahead of this key round |
| half_sel | input | 1 | 0 selects the right half, 1 the left half, onto `rk` |
| rc_idx | input | IDX_W | Round index added to word 0 |
| rk | output | N_BITS/2 | Round-key half for the current round |

## Verification
Every register update (load, round, exchanged round, hold) shows up at the key halves one clock edge after the cycle that commands it. The `rk` output follows `half_sel` combinationally in the same cycle. The bench therefore drives commands 1 ns after a rising edge and waits for the next rising edge. It then changes `half_sel` and reads `rk` a further 1 ns later, which keeps every sample clear of the edge. The full-schedule runs check one round key per cycle, just before that cycle's command is issued. This matches the point at which the data path would consume the key.

// File: rtl/sks_pkg.sv
package sks_pkg;

    // Register update selected for the current cycle, in priority order.
    typedef enum logic [1:0] {
        UPD_HOLD       = 2'd0,
        UPD_LOAD       = 2'd1,
        UPD_ROUND      = 2'd2,
        UPD_ROUND_SWAP = 2'd3
    } upd_e;

    // 3-bit substitution used across word triples.
    function automatic logic [2:0] sbox3(input logic [2:0] v);
        logic [2:0] s;
        unique case (v)
            3'd0:    s = 3'd0;
            3'd1:    s = 3'd5;
            3'd2:    s = 3'd6;
            3'd3:    s = 3'd7;
            3'd4:    s = 3'd4;
            3'd5:    s = 3'd3;
            3'd6:    s = 3'd1;
            default: s = 3'd2;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sks_sbox_layer.sv
// Bit-sliced substitution over groups of three words (R5).
module sks_sbox_layer
    import sks_pkg::*;
#(
    parameter int W  = 8,
    parameter int NB = 3
) (
    input  logic [NB*W-1:0] din,
    output logic [NB*W-1:0] dout
);
    localparam int GROUPS = NB / 3;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar j = 0; j < W; j++) begin : g_bit
            assign {dout[(3*g+2)*W+j], dout[(3*g+1)*W+j], dout[(3*g)*W+j]} =
                sbox3({din[(3*g+2)*W+j], din[(3*g+1)*W+j], din[(3*g)*W+j]});
        end
    end
endmodule

// File: rtl/sks_key_round.sv
// One key round: new left = right, new right = left ^ T(right, idx).
module sks_key_round #(
    parameter int W     = 8,
    parameter int NB    = 3,
    parameter int IDX_W = 8
) (
    input  logic [NB*W-1:0] in_l,
    input  logic [NB*W-1:0] in_r,
    input  logic [IDX_W-1:0] idx,
    output logic [NB*W-1:0] out_l,
    output logic [NB*W-1:0] out_r
);
    localparam int HALF   = NB * W;
    localparam int GROUPS = NB / 3;

    logic [HALF-1:0] summed;
    logic [HALF-1:0] subst;
    logic [HALF-1:0] brot;
    logic [HALF-1:0] wrot;

    // R4: only the least significant word carries the constant.
    assign summed[W-1:0]    = in_r[W-1:0] + W'(idx);
    assign summed[HALF-1:W] = in_r[HALF-1:W];

    sks_sbox_layer #(.W(W), .NB(NB)) u_sbox (
        .din  (summed),
        .dout (subst)
    );

    // R6: bit rotation inside each word triple (wiring only).
    for (genvar g = 0; g < GROUPS; g++) begin : g_brot
        localparam int B0 = (3*g) * W;
        localparam int B1 = (3*g+1) * W;
        localparam int B2 = (3*g+2) * W;
        assign brot[B0 +: W] = {subst[B0], subst[B0+W-1:B0+1]};
        assign brot[B1 +: W] = subst[B1 +: W];
        assign brot[B2 +: W] = {subst[B2+W-2:B2], subst[B2+W-1]};
    end

    // R6: word rotation towards higher positions (wiring only).
    assign wrot  = {brot[HALF-W-1:0], brot[HALF-1 -: W]};

    assign out_l = in_r;
    assign out_r = in_l ^ wrot;
endmodule

// File: rtl/sks_key_sched.sv
module sks_key_sched
    import sks_pkg::*;
#(
    parameter int N_BITS = 48,
    parameter int W      = 8,
    parameter int IDX_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [N_BITS-1:0]     key,
    input  logic                  advance,
    input  logic                  swap,
    input  logic                  half_sel,
    input  logic [IDX_W-1:0]      rc_idx,
    output logic [N_BITS/2-1:0]   rk
);
    localparam int HALF = N_BITS / 2;
    localparam int NB   = HALF / W;

    upd_e            upd_sel;
    logic [HALF-1:0] kl_q, kr_q;
    logic [HALF-1:0] rin_l, rin_r;
    logic [HALF-1:0] rout_l, rout_r;

    // Update selection: load first, then a round, else hold.
    always_comb begin
        if (load)
            upd_sel = UPD_LOAD;
        else if (advance && swap)
            upd_sel = UPD_ROUND_SWAP;
        else if (advance)
            upd_sel = UPD_ROUND;
        else
            upd_sel = UPD_HOLD;
    end

    // R7: exchanged halves feed the round on the midpoint cycle.
    always_comb begin
        if (upd_sel == UPD_ROUND_SWAP) begin
            rin_l = kr_q;
            rin_r = kl_q;
        end else begin
            rin_l = kl_q;
            rin_r = kr_q;
        end
    end

    sks_key_round #(.W(W), .NB(NB), .IDX_W(IDX_W)) u_round (
        .in_l  (rin_l),
        .in_r  (rin_r),
        .idx   (rc_idx),
        .out_l (rout_l),
        .out_r (rout_r)
    );

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kl_q <= '0;
            kr_q <= '0;
        end else begin
            unique case (upd_sel)
                UPD_LOAD: begin
                    kl_q <= key[N_BITS-1:HALF];
                    kr_q <= key[HALF-1:0];
                end
                UPD_ROUND, UPD_ROUND_SWAP: begin
                    kl_q <= rout_l;
                    kr_q <= rout_r;
                end
                UPD_HOLD: begin
                    kl_q <= kl_q;
                    kr_q <= kr_q;
                end
            endcase
        end
    end

    // Output process: half selection for the data path.
    always_comb begin
        rk = half_sel ? kl_q : kr_q;
    end
endmodule

// File: rtl/sks_key_sched_chk.sv
module sks_key_sched_chk #(
    parameter int N_BITS = 48
) (
    input logic                clk,
    input logic                rst_n,
    input logic                load,
    input logic                advance,
    input logic                swap,
    input logic [N_BITS-1:0]   key,
    input logic [N_BITS/2-1:0] kl_q,
    input logic [N_BITS/2-1:0] kr_q
);
    localparam int HALF = N_BITS / 2;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (kl_q == '0 && kr_q == '0));

    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (kl_q == $past(key[N_BITS-1:HALF]) && kr_q == $past(key[HALF-1:0])));

    p_round_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !swap && !load) |=> (kl_q == $past(kr_q)));

    p_swap_keeps_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && swap && !load) |=> (kl_q == $past(kl_q)));

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> ($stable(kl_q) && $stable(kr_q)));
endmodule

bind sks_key_sched sks_key_sched_chk #(.N_BITS(N_BITS)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .advance (advance),
    .swap    (swap),
    .key     (key),
    .kl_q    (kl_q),
    .kr_q    (kr_q)
);

// File: tb/test_sks_key_sched.sv
module test_sks_key_sched;
    localparam int N = 48;
    localparam int H = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [N-1:0]  key = '0;
    logic          advance = 1'b0;
    logic          swap = 1'b0;
    logic          half_sel = 1'b0;
    logic [7:0]    rc_idx = '0;
    logic [H-1:0]  rk;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    sks_key_sched #(.N_BITS(N), .W(8), .IDX_W(8)) i_sks_key_sched (
        .clk(clk), .rst_n(rst_n), .load(load), .key(key),
        .advance(advance), .swap(swap), .half_sel(half_sel),
        .rc_idx(rc_idx), .rk(rk)
    );

    // Stimulus table: key and schedule length per run (R10).
    localparam logic [N-1:0] KEYS [0:3] = '{
        48'h0123_4567_89AB, 48'hFFFF_FFFF_FFFF,
        48'hA5C3_0F1E_7D29, 48'h0000_0000_0001
    };
    localparam int NRS [0:3] = '{5, 7, 9, 11};
    localparam logic [2:0] SB [0:7] = '{3'd0, 3'd5, 3'd6, 3'd7, 3'd4, 3'd3, 3'd1, 3'd2};

    // Reference key round from R3..R6; returns {new_left, new_right}.
    function automatic logic [N-1:0] ref_round(input logic [H-1:0] l,
                                               input logic [H-1:0] r,
                                               input logic [7:0] c);
        logic [7:0] w [0:2];
        logic [7:0] s [0:2];
        logic [7:0] b [0:2];
        logic [2:0] o;
        for (int i = 0; i < 3; i++) w[i] = r[i*8 +: 8];
        w[0] = w[0] + c;
        for (int j = 0; j < 8; j++) begin
            o = SB[{w[2][j], w[1][j], w[0][j]}];
            s[0][j] = o[0];
            s[1][j] = o[1];
            s[2][j] = o[2];
        end
        b[0] = (s[0] >> 1) | (s[0] << 7);
        b[1] = s[1];
        b[2] = (s[2] << 1) | (s[2] >> 7);
        return {r, l ^ {b[1], b[0], b[2]}};
    endfunction

    task automatic cyc(input logic ld, input logic [N-1:0] k, input logic adv,
                       input logic sw, input logic [7:0] ix);
        load = ld; key = k; advance = adv; swap = sw; rc_idx = ix;
        @(posedge clk);
        #1;
        load = 1'b0; advance = 1'b0; swap = 1'b0;
    endtask

    task automatic chk(input logic hs, input logic [H-1:0] exp, input string tag);
        half_sel = hs;
        #1;
        checks++;
        if (rk !== exp) begin
            failures++;
            $display("FAIL %s rk=%h expected %h", tag, rk, exp);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [H-1:0] ml, mr, a, b;
        logic [N-1:0] nxt;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(1'b0, 24'h0, "R1 reset right");
        chk(1'b1, 24'h0, "R1 reset left");
        rst_n = 1'b1;

        // Table-driven full schedules (R9, R10)
        for (int k = 0; k < 4; k++) begin
            int nr = NRS[k];
            int fl = nr / 2;
            cyc(1'b1, KEYS[k], 1'b0, 1'b0, 8'd0);
            ml = KEYS[k][N-1:H];
            mr = KEYS[k][H-1:0];
            for (int t = 0; t < nr; t++) begin
                logic hs;
                logic [7:0] ix;
                logic sw;
                hs = (t > fl);
                chk(hs, hs ? ml : mr, $sformatf("R10 run%0d round%0d R9", k, t + 1));
                if (t < nr - 1) begin
                    ix = (t < fl) ? 8'(t + 1) : 8'(nr - 1 - t);
                    sw = (t == fl);
                    a = sw ? mr : ml;
                    b = sw ? ml : mr;
                    nxt = ref_round(a, b, ix);
                    ml = nxt[N-1:H];
                    mr = nxt[H-1:0];
                    cyc(1'b0, '0, 1'b1, sw, ix);
                end
            end
        end

        // R3/R4/R5/R6 hand vector: zero key, index 1
        cyc(1'b1, 48'h0, 1'b0, 1'b0, 8'd0);
        cyc(1'b0, '0, 1'b1, 1'b0, 8'd1);
        chk(1'b1, 24'h000000, "R3 left takes old right");
        chk(1'b0, 24'h008002, "R5 R6 right after sbox and rotations");

        // R4: word 0 wraps modulo 2^W with no carry out
        cyc(1'b1, 48'h000000_0000FF, 1'b0, 1'b0, 8'd0);
        cyc(1'b0, '0, 1'b1, 1'b0, 8'd1);
        chk(1'b1, 24'h0000FF, "R4 left");
        chk(1'b0, 24'h000000, "R4 wrap right");

        // R7: exchanged round
        cyc(1'b1, 48'h000000_123456, 1'b0, 1'b0, 8'd0);
        cyc(1'b0, '0, 1'b1, 1'b1, 8'd1);
        chk(1'b1, 24'h000000, "R7 left");
        chk(1'b0, 24'h12B454, "R7 right");

        // R2: load wins over advance
        cyc(1'b1, 48'h9ABCDE_F01234, 1'b1, 1'b1, 8'd3);
        chk(1'b1, 24'h9ABCDE, "R2 left");
        chk(1'b0, 24'hF01234, "R2 right");

        // R8: no advance, swap ignored
        cyc(1'b0, '0, 1'b0, 1'b1, 8'd7);
        cyc(1'b0, '0, 1'b0, 1'b1, 8'd2);
        chk(1'b1, 24'h9ABCDE, "R8 left held");
        chk(1'b0, 24'hF01234, "R8 right held");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule